// File: doc/BRIEF.md
# Sleep Entry and Interrupt Wake-Up Controller

This block sits next to a small processor core and governs its power-down mode. The core raises a one-cycle strobe when it executes its sleep instruction. The block then compares the interrupt enable and flag vectors on that same clock edge and makes one of two choices. If a source is already pending, the sleep acts as a no-op. If no source is pending, the block halts the core, pulses a clear to the watchdog and updates the two status bits. Those bits are the time-out flag and the power-down flag.

While the core sleeps, any enabled source whose flag rises wakes it. The global interrupt enable has no part in this. Oscillator modes 0, 1 and 2 are the crystal types, and in those modes the core stays halted for a start-up count of oscillator cycles before it runs. Mode 3 is the internal oscillator and releases the core at once. After the release, the core fetches the next instruction for one cycle. If the global enable was set at the wake edge, the block then marks one dummy cycle and asks the core to redirect to the interrupt vector. If the global enable was clear, execution carries on in-line.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: On reset, the time-out flag (`to_flag`) and the power-down flag (`pd_flag`) both read 1. `core_halt`, `wdt_clr`, `vec_req` and `dummy_cycle` all read 0.
- R2: A wake condition is any bit position where `irq_en` and `irq_flag` are both 1. `glob_ie` does not affect it.
- R3: If a wake condition is present on the edge that samples `sleep_exec`, the sleep is a no-op. `core_halt` stays 0, `wdt_clr` does not pulse, and `to_flag` and `pd_flag` keep their values.
- R4: If no wake condition is present on that edge, then in the next cycle `core_halt`=1, `to_flag`=1 and `pd_flag`=0, and `wdt_clr` is 1 for exactly that one cycle.
- R5: While sleeping, the core stays halted until a wake condition appears. A flag without its enable, or an enable without its flag, keeps it asleep.
- R6: In crystal modes (`osc_mode` 0, 1 or 2, sampled at the wake edge), `core_halt` stays 1 for exactly OST_CYCLES cycles (1024 by default) after the wake edge, then falls.
- R7: In mode 3, `core_halt` falls in the cycle right after the wake edge.
- R8: If `glob_ie` was 1 at the wake edge, `vec_req` and `dummy_cycle` are 1 together for one cycle. That cycle is the second cycle after `core_halt` falls.
- R9: If `glob_ie` was 0 at the wake edge, neither `vec_req` nor `dummy_cycle` is asserted after the wake.
- R10: A `sleep_exec` strobe is ignored while the core is halted. It produces no `wdt_clr` pulse.
- R11: The start-up count restarts from zero on every sleep entry, so each crystal-mode wake takes the full OST_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on / brown-out reset |
| sleep_exec | input | 1 | One-cycle strobe: the core is executing its sleep instruction |
| irq_en | input | NSRC | Per-source interrupt enable bits |
| irq_flag | input | NSRC | Per-source interrupt flag bits |
| glob_ie | input | 1 | Global interrupt enable |
| osc_mode | input | 2 | Oscillator type: 0..2 crystal, 3 internal |
| core_halt | output | 1 | Holds the core stopped |
| wdt_clr | output | 1 | One-cycle clear for the watchdog and its prescaler |
| to_flag | output | 1 | Time-out status bit |
| pd_flag | output | 1 | Power-down status bit |
| vec_req | output | 1 | Request to redirect execution to the interrupt vector |
| dummy_cycle | output | 1 | Marks the inserted dummy cycle |

## Verification
A bad no-op decision shows at the ports on the very next cycle. It appears as a missing or extra `wdt_clr` pulse, a wrong `pd_flag`, or a `core_halt` in the wrong state. A start-up counter that is not cleared, or that stops at the wrong value, shows as a halt of the wrong length after wake-up. That error is measured to the exact cycle and can only be seen about a thousand cycles after the wake edge. A wrong latched global enable shows two cycles after the halt drops, as a missing or unwanted vector request.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        OSC_LP  = 2'd0,
        OSC_XT  = 2'd1,
        OSC_HS  = 2'd2,
        OSC_INT = 2'd3
    } osc_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_OST,
        ST_RESUME,
        ST_DUMMY
    } slp_state_e;

    typedef struct packed {
        logic to;
        logic pd;
    } slp_stat_t;

    localparam slp_stat_t STAT_RESET = '{to: 1'b1, pd: 1'b1};
    localparam slp_stat_t STAT_SLEPT = '{to: 1'b1, pd: 1'b0};

    function automatic logic needs_startup(osc_mode_e m);
        return m != OSC_INT;
    endfunction

endpackage

// File: rtl/wake_detect.sv
module wake_detect #(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0] irq_en,
    input  logic [NSRC-1:0] irq_flag,
    output logic            wake_any
);
    logic [NSRC-1:0] hit;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            assign hit[i] = irq_en[i] & irq_flag[i];
        end
    endgenerate

    assign wake_any = |hit;
endmodule

// File: rtl/ost_counter.sv
module ost_counter #(
    parameter int CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_exec,
    input  logic       wake_any,
    input  logic       glob_ie,
    input  logic [1:0] osc_mode,
    input  logic       ost_done,
    output slp_state_e state,
    output slp_stat_t  stat,
    output logic       wdt_clr,
    output logic       ost_clear,
    output logic       fsm_idle
);
    logic gie_q;

    assign fsm_idle  = (state == ST_RUN);
    assign ost_clear = (fsm_idle && sleep_exec) || (state == ST_SLEEP && wake_any);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RUN;
            stat    <= STAT_RESET;
            wdt_clr <= 1'b0;
            gie_q   <= 1'b0;
        end else begin
            wdt_clr <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (sleep_exec && !wake_any) begin
                        state   <= ST_SLEEP;
                        stat    <= STAT_SLEPT;
                        wdt_clr <= 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (wake_any) begin
                        gie_q <= glob_ie;
                        state <= needs_startup(osc_mode_e'(osc_mode)) ? ST_OST : ST_RESUME;
                    end
                end
                ST_OST: begin
                    if (ost_done) state <= ST_RESUME;
                end
                ST_RESUME: state <= gie_q ? ST_DUMMY : ST_RUN;
                ST_DUMMY:  state <= ST_RUN;
                default:   state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import slp_pkg::*;
#(
    parameter int NSRC       = 8,
    parameter int OST_CYCLES = 1024
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep_exec,
    input  logic [NSRC-1:0] irq_en,
    input  logic [NSRC-1:0] irq_flag,
    input  logic            glob_ie,
    input  logic [1:0]      osc_mode,
    output logic            core_halt,
    output logic            wdt_clr,
    output logic            to_flag,
    output logic            pd_flag,
    output logic            vec_req,
    output logic            dummy_cycle
);
    logic       wake_any;
    logic       ost_done;
    logic       ost_clear;
    logic       fsm_idle;
    slp_state_e state;
    slp_stat_t  stat;

    wake_detect #(.NSRC(NSRC)) u_wake (
        .irq_en   (irq_en),
        .irq_flag (irq_flag),
        .wake_any (wake_any)
    );

    ost_counter #(.CYCLES(OST_CYCLES)) u_ost (
        .clk   (clk),
        .rst   (rst),
        .clear (ost_clear),
        .run   (state == ST_OST),
        .done  (ost_done)
    );

    sleep_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sleep_exec (sleep_exec),
        .wake_any   (wake_any),
        .glob_ie    (glob_ie),
        .osc_mode   (osc_mode),
        .ost_done   (ost_done),
        .state      (state),
        .stat       (stat),
        .wdt_clr    (wdt_clr),
        .ost_clear  (ost_clear),
        .fsm_idle   (fsm_idle)
    );

    assign core_halt   = (state == ST_SLEEP) || (state == ST_OST);
    assign vec_req     = (state == ST_DUMMY);
    assign dummy_cycle = (state == ST_DUMMY);
    assign to_flag     = stat.to;
    assign pd_flag     = stat.pd;
endmodule

// File: rtl/sleep_wake_chk.sv
module sleep_wake_chk (
    input logic clk,
    input logic rst,
    input logic sleep_exec,
    input logic wake_any,
    input logic fsm_idle,
    input logic ost_done,
    input logic core_halt,
    input logic wdt_clr,
    input logic to_flag,
    input logic pd_flag,
    input logic vec_req
);
    AST_RESET_STATUS: assert property (@(posedge clk)
        rst |=> (to_flag && pd_flag && !core_halt && !wdt_clr && !vec_req)); // R1

    AST_NOOP_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (sleep_exec && wake_any && fsm_idle) |=> (!wdt_clr && !core_halt && $stable(pd_flag) && $stable(to_flag))); // R3

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (sleep_exec && !wake_any && fsm_idle) |=> (core_halt && wdt_clr && to_flag && !pd_flag)); // R4

    AST_WDT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |=> !wdt_clr); // R4

    AST_HALT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(core_halt) |-> ($past(wake_any) || $past(ost_done))); // R6

    AST_IGNORE_WHILE_HALTED: assert property (@(posedge clk) disable iff (rst)
        (core_halt && sleep_exec) |=> !wdt_clr); // R10

    AST_VEC_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> (!core_halt && !$past(core_halt))); // R8
endmodule

bind sleep_wake_ctrl sleep_wake_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep_exec (sleep_exec),
    .wake_any   (wake_any),
    .fsm_idle   (fsm_idle),
    .ost_done   (ost_done),
    .core_halt  (core_halt),
    .wdt_clr    (wdt_clr),
    .to_flag    (to_flag),
    .pd_flag    (pd_flag),
    .vec_req    (vec_req)
);

// File: tb/sleep_wake_ctrl_tb_top.sv
module sleep_wake_ctrl_tb_top;
    localparam int NSRC = 8;
    localparam int OST  = 1024;

    typedef struct packed {
        logic [7:0] en;
        logic [7:0] fl;
        logic       gie;
        logic       pend;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{8'h00, 8'hFF, 1'b1, 1'b0},
        '{8'hFF, 8'h00, 1'b1, 1'b0},
        '{8'h01, 8'h01, 1'b1, 1'b1},
        '{8'h80, 8'h81, 1'b0, 1'b1},
        '{8'h0F, 8'hF0, 1'b0, 1'b0},
        '{8'h24, 8'h20, 1'b0, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sleep_exec = 1'b0;
    logic [NSRC-1:0] irq_en = '0;
    logic [NSRC-1:0] irq_flag = '0;
    logic            glob_ie = 1'b0;
    logic [1:0]      osc_mode = 2'd3;
    logic core_halt, wdt_clr, to_flag, pd_flag, vec_req, dummy_cycle;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sleep_wake_ctrl #(.NSRC(NSRC), .OST_CYCLES(OST)) dut_i (
        .clk(clk), .rst(rst), .sleep_exec(sleep_exec), .irq_en(irq_en),
        .irq_flag(irq_flag), .glob_ie(glob_ie), .osc_mode(osc_mode),
        .core_halt(core_halt), .wdt_clr(wdt_clr), .to_flag(to_flag),
        .pd_flag(pd_flag), .vec_req(vec_req), .dummy_cycle(dummy_cycle)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_sleep();
        sleep_exec = 1'b1;
        @(negedge clk);
        sleep_exec = 1'b0;
    endtask

    task automatic count_halt(output int n);
        n = 0;
        @(negedge clk);
        while (core_halt && n < 3000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 to", int'(to_flag), 1);
        chk("R1 pd", int'(pd_flag), 1);
        chk("R1 halt", int'(core_halt), 0);
        chk("R1 wdt", int'(wdt_clr), 0);
        chk("R1 vec", int'(vec_req), 0);

        // R3 pending source makes sleep a no-op; status keeps reset values
        irq_en = 8'h10; irq_flag = 8'h10;
        pulse_sleep();
        chk("R3 halt", int'(core_halt), 0);
        chk("R3 wdt", int'(wdt_clr), 0);
        chk("R3 pd", int'(pd_flag), 1);
        chk("R3 to", int'(to_flag), 1);
        irq_en = '0; irq_flag = '0;
        @(negedge clk);

        // R2 wake-condition table, internal oscillator
        osc_mode = 2'd3;
        foreach (TBL[i]) begin
            irq_en = TBL[i].en; irq_flag = TBL[i].fl; glob_ie = TBL[i].gie;
            pulse_sleep();
            chk($sformatf("R2 halt row %0d", i), int'(core_halt), int'(!TBL[i].pend));
            chk($sformatf("R2 wdt row %0d", i), int'(wdt_clr), int'(!TBL[i].pend));
            if (core_halt) begin
                irq_en = 8'h01; irq_flag = 8'h01;
                @(negedge clk);
                chk("R7 immediate release", int'(core_halt), 0);
            end
            irq_en = '0; irq_flag = '0;
            repeat (3) @(negedge clk);
        end

        // R4, R5, R10, R6, R8: crystal XT wake with global enable
        osc_mode = 2'd1; glob_ie = 1'b1;
        irq_en = 8'h02; irq_flag = 8'h01;
        pulse_sleep();
        chk("R4 halt", int'(core_halt), 1);
        chk("R4 wdt", int'(wdt_clr), 1);
        chk("R4 to", int'(to_flag), 1);
        chk("R4 pd", int'(pd_flag), 0);
        @(negedge clk);
        chk("R4 wdt one cycle", int'(wdt_clr), 0);
        pulse_sleep();
        chk("R10 no wdt while halted", int'(wdt_clr), 0);
        repeat (5) @(negedge clk);
        chk("R5 still halted", int'(core_halt), 1);
        irq_flag = 8'h03;
        count_halt(n);
        chk("R6 XT startup length", n, OST);
        @(negedge clk);
        chk("R8 vec", int'(vec_req), 1);
        chk("R8 dummy", int'(dummy_cycle), 1);
        @(negedge clk);
        chk("R8 vec single", int'(vec_req), 0);
        irq_en = '0; irq_flag = '0;
        repeat (2) @(negedge clk);

        // R11, R9: second crystal sleep (LP), global enable off
        osc_mode = 2'd0; glob_ie = 1'b0;
        pulse_sleep();
        repeat (3) @(negedge clk);
        irq_en = 8'h40; irq_flag = 8'h40;
        count_halt(n);
        chk("R11 full count again", n, OST);
        @(negedge clk);
        chk("R9 no vec", int'(vec_req), 0);
        chk("R9 no dummy", int'(dummy_cycle), 0);
        @(negedge clk);
        chk("R9 no vec later", int'(vec_req), 0);
        irq_en = '0; irq_flag = '0;
        @(negedge clk);

        // R7 internal oscillator wake with gie
        osc_mode = 2'd3; glob_ie = 1'b1;
        pulse_sleep();
        irq_en = 8'h80; irq_flag = 8'h80;
        count_halt(n);
        chk("R7 no startup", n, 0);
        @(negedge clk);
        chk("R8 vec after internal wake", int'(vec_req), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule